// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns parallel audio sample words into a serial bit stream. The bit clock and the frame sync are generated elsewhere. Both are seen here as signals in the system clock domain: `bit_tick` is a one-cycle strobe at each falling bit-clock edge, which is the point where a new bit is driven, and `fsync` is the frame-sync level sampled at that strobe. Each frame-sync assertion starts a phase. The phase holds a programmed number of words of 16 or 32 bits, sent MSB first and back to back. An optional one-bit-period data delay can be inserted, and an optional second phase can follow at once for two-slot stereo formats.

Samples come in over a valid/ready handshake. The block raises `s_ready` and `word_strobe` in the single cycle in which a word begins on the line. If no sample is waiting at that moment, the word is sent as zeros and a sticky flag records it. A frame sync that arrives while a phase is still in progress restarts the phase and sets a second sticky flag. Receive, FIFOs and clock generation belong to other blocks.

Top module: `sat_tx`

## Requirements
- R1: After reset, `sdata`, `s_ready`, `word_strobe`, `underflow` and `fs_error` are all 0.
- R2: The word length code `cfg_wlen` selects 32-bit words when it is 5. Any other code selects 16-bit words, which are taken from `s_data[15:0]`.
- R3: Each word is sent MSB first, one bit per bit period. The first bit of a frame is the MSB of its first word, and the next word follows the last bit of the previous word with no gap.
- R4: `cfg_len` holds the number of words per phase minus one, from 0 to 127. A single-phase frame carries `cfg_len`+1 words.
- R5: With `cfg_dual`=1, a second phase of the same size follows the first phase with no gap, so one frame-sync edge sends 2×(`cfg_len`+1) words.
- R6: With `cfg_delay`=0, the MSB is driven in the bit period that starts at the tick where the frame-sync edge is seen. With `cfg_delay`=1, the line is 0 for that one bit period and the MSB follows one tick later.
- R7: With `cfg_fs_pol`=0, frame sync is active low; with `cfg_fs_pol`=1 it is active high. A phase starts only at a tick where frame sync is active and was inactive at the previous tick, so holding it active for many ticks starts only one phase.
- R8: `s_ready` and `word_strobe` are high for exactly the one clock, on a tick, in which a word begins. The sample is consumed in that cycle when `s_valid` is high.
- R9: If `s_valid` is low when a word begins, the word is sent as all zeros and `underflow` is set and stays set until reset.
- R10: A frame-sync edge that arrives before the last bit of the phase has been sent restarts the frame and sets `fs_error`, which stays set until reset. An edge at the tick right after the last bit does not set it.
- R11: When no frame is in progress, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-clock drive edge |
| fsync | input | 1 | Frame-sync level, sampled at `bit_tick` |
| cfg_wlen | input | 3 | Word length code (5 = 32 bits, otherwise 16 bits) |
| cfg_len | input | 7 | Words per phase minus one |
| cfg_dual | input | 1 | 1 = two phases per frame |
| cfg_delay | input | 1 | Data delay in bit periods (0 or 1) |
| cfg_fs_pol | input | 1 | 1 = frame sync active high |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | Sample taken in this cycle |
| word_strobe | output | 1 | A word starts in this cycle |
| sdata | output | 1 | Serial data line |
| underflow | output | 1 | Sticky: a word was sent without a sample |
| fs_error | output | 1 | Sticky: frame sync arrived mid-phase |

## Verification
The hardest corner to reach is the boundary of the frame-sync error: an edge exactly one tick after the last bit must be accepted cleanly, while one tick earlier must restart the frame and raise the flag. The stimulus spaces frame-sync edges at exactly the frame length in bit periods, with and without the delay slot, and then deliberately cuts a frame short in the middle of a word. Underflow is forced by feeding fewer samples than a frame needs. Level-held frame sync is driven over many ticks to show that only the edge starts a phase.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned SAT_DW    = 32;
  localparam int unsigned SAT_LEN_W = 7;
  localparam int unsigned SAT_IDX_W = $clog2(SAT_DW);
  localparam int unsigned SAT_CNT_W = SAT_LEN_W + 2;

  typedef enum logic [2:0] {
    WL_8  = 3'd0,
    WL_12 = 3'd1,
    WL_16 = 3'd2,
    WL_20 = 3'd3,
    WL_24 = 3'd4,
    WL_32 = 3'd5
  } wlen_code_e;

  // bits in one word for a given length code
  function automatic logic [SAT_IDX_W:0] word_bits(logic [2:0] code);
    return (code == WL_32) ? (SAT_IDX_W+1)'(32) : (SAT_IDX_W+1)'(16);
  endfunction

  // words sent after one frame-sync edge
  function automatic logic [SAT_CNT_W-1:0] frame_words(logic [SAT_LEN_W-1:0] len,
                                                       logic dual);
    logic [SAT_CNT_W-1:0] per;
    per = SAT_CNT_W'(len) + 1'b1;
    return dual ? (per << 1) : per;
  endfunction
endpackage

// File: rtl/sat_fs_edge.sv
module sat_fs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic fsync,
  input  logic fs_pol,
  output logic fs_start
);
  logic act;
  logic act_q;

  assign act = fs_pol ? fsync : ~fsync;

  always_ff @(posedge clk) begin
    if (!rst_n)        act_q <= 1'b0;
    else if (bit_tick) act_q <= act;
  end

  assign fs_start = bit_tick & act & ~act_q;

  // R7
  fs_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_start |=> !fs_start);
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          clear,
  input  logic [DW-1:0] word_in,
  output logic          ser_out
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= word_in;
    else if (shift) sh <= {sh[DW-2:0], 1'b0};
    else if (clear) sh <= '0;
  end

  assign ser_out = sh[DW-1];

  // R3
  msb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> ser_out == $past(sh[DW-2]));
endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
  import sat_pkg::*;
#(
  parameter int unsigned IDX_W = SAT_IDX_W,
  parameter int unsigned CNT_W = SAT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fs_start,
  input  logic             dly,
  input  logic [IDX_W:0]   wbits,
  input  logic [CNT_W-1:0] total,
  output logic             load_word,
  output logic             shift_bit,
  output logic             clear_line,
  output logic             early_fs,
  output logic             in_frame
);
  logic             busy;
  logic             pend;
  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] words_rem;
  logic             last_bit;
  logic             more;
  logic             finished;

  assign last_bit = (bit_idx == '0);
  assign more     = (words_rem != '0);
  assign finished = ~pend & (~busy | (last_bit & ~more));
  assign in_frame = busy | pend;

  assign early_fs   = bit_tick & fs_start & ~finished;
  assign load_word  = bit_tick & ((fs_start & ~dly) |
                                  (~fs_start & pend) |
                                  (~fs_start & busy & last_bit & more));
  assign shift_bit  = bit_tick & ~fs_start & ~pend & busy & ~last_bit;
  assign clear_line = bit_tick & ~load_word & ~shift_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      bit_idx   <= '0;
      words_rem <= '0;
    end else if (bit_tick) begin
      if (fs_start) begin
        pend      <= dly;
        busy      <= ~dly;
        words_rem <= total - 1'b1;
        bit_idx   <= IDX_W'(wbits - 1'b1);
      end else if (load_word) begin
        pend    <= 1'b0;
        busy    <= 1'b1;
        bit_idx <= IDX_W'(wbits - 1'b1);
        if (!pend) words_rem <= words_rem - 1'b1;
      end else if (shift_bit) begin
        bit_idx <= bit_idx - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  // R4
  words_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> words_rem < total);

  // R6
  delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_start && dly) |=> (pend && !busy && !load_word));
endmodule

// File: rtl/sat_tx.sv
module sat_tx
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = SAT_DW,
  parameter int unsigned LEN_W  = SAT_LEN_W,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic [2:0]        cfg_wlen,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_dual,
  input  logic              cfg_delay,
  input  logic              cfg_fs_pol,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              word_strobe,
  output logic              sdata,
  output logic              underflow,
  output logic              fs_error
);
  logic [IDX_W:0]    wb;
  logic [CNT_W-1:0]  total;
  logic [IDX_W:0]    shamt;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] word_in;
  logic              fs_start;
  logic              load_word;
  logic              shift_bit;
  logic              clear_line;
  logic              early_fs;
  logic              in_frame;

  assign wb      = word_bits(cfg_wlen);
  assign total   = frame_words(cfg_len, cfg_dual);
  assign shamt   = (IDX_W+1)'(DATA_W) - wb;
  assign aligned = s_data << shamt;
  assign word_in = s_valid ? aligned : '0;

  sat_fs_edge u_fs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .fsync    (fsync),
    .fs_pol   (cfg_fs_pol),
    .fs_start (fs_start)
  );

  sat_frame_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fs_start   (fs_start),
    .dly        (cfg_delay),
    .wbits      (wb),
    .total      (total),
    .load_word  (load_word),
    .shift_bit  (shift_bit),
    .clear_line (clear_line),
    .early_fs   (early_fs),
    .in_frame   (in_frame)
  );

  sat_shifter #(.DW(DATA_W)) u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_word),
    .shift   (shift_bit),
    .clear   (clear_line),
    .word_in (word_in),
    .ser_out (sdata)
  );

  assign s_ready     = load_word;
  assign word_strobe = load_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underflow <= 1'b0;
      fs_error  <= 1'b0;
    end else begin
      if (load_word && !s_valid) underflow <= 1'b1;
      if (early_fs)              fs_error  <= 1'b1;
    end
  end

  // R8
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick);

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> sdata == $past(aligned[DATA_W-1]));

  // R9
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> !sdata);

  // R9
  uflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R10
  fserr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_error |=> fs_error);

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_line |=> !sdata);
endmodule

// File: tb/sat_tx_bench.sv
module sat_tx_bench;
  localparam int TICK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick;
  logic        fsync;
  logic [2:0]  cfg_wlen;
  logic [6:0]  cfg_len;
  logic        cfg_dual;
  logic        cfg_delay;
  logic        cfg_fs_pol;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready;
  logic        word_strobe;
  logic        sdata;
  logic        underflow;
  logic        fs_error;

  always #2 clk = ~clk;

  sat_tx u_sat_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .cfg_wlen(cfg_wlen), .cfg_len(cfg_len), .cfg_dual(cfg_dual),
    .cfg_delay(cfg_delay), .cfg_fs_pol(cfg_fs_pol),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .word_strobe(word_strobe), .sdata(sdata),
    .underflow(underflow), .fs_error(fs_error)
  );

  int checks = 0;
  int fails  = 0;
  bit          q[$];
  logic [31:0] src[$];
  int          wleft;
  bit          pend, prev, exp_line, exp_uf, exp_err, exp_ready, feed;
  string       req;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      src.push_back(seed);
    end
  endtask

  // behavioural reference: a queue of bits still to go out
  task automatic model_step();
    bit act, st, skip;
    logic [31:0] w;
    int nb;
    exp_ready = 1'b0;
    if (!bit_tick) return;
    act  = cfg_fs_pol ? fsync : ~fsync;
    st   = act && !prev;
    prev = act;
    skip = 1'b0;
    if (st) begin
      if (pend || q.size() > 0 || wleft > 0) exp_err = 1'b1;
      q.delete();
      wleft = (int'(cfg_len) + 1) * (cfg_dual ? 2 : 1);
      pend  = cfg_delay;
      skip  = cfg_delay;
    end else if (pend) begin
      pend = 1'b0;
    end
    if (!skip && q.size() == 0 && wleft > 0) begin
      wleft--;
      exp_ready = 1'b1;
      nb = (cfg_wlen == 3'd5) ? 32 : 16;
      w  = s_valid ? s_data : 32'h0;
      if (!s_valid) exp_uf = 1'b1;
      for (int i = nb - 1; i >= 0; i--) q.push_back(w[i]);
    end
    exp_line = (q.size() > 0) ? q.pop_front() : 1'b0;
  endtask

  task automatic cyc(bit tk, bit act);
    @(negedge clk);
    chk(sdata === exp_line, req, "sdata", int'(sdata), int'(exp_line));
    chk(underflow === exp_uf, "R9", "underflow", int'(underflow), int'(exp_uf));
    chk(fs_error === exp_err, "R10", "fs_error", int'(fs_error), int'(exp_err));
    bit_tick = tk;
    fsync    = cfg_fs_pol ? act : ~act;
    s_valid  = feed && src.size() > 0;
    s_data   = s_valid ? src[0] : 32'h0;
    #1;
    model_step();
    chk(s_ready === exp_ready, "R8", "s_ready", int'(s_ready), int'(exp_ready));
    chk(word_strobe === exp_ready, "R8", "word_strobe", int'(word_strobe), int'(exp_ready));
    if (exp_ready && s_valid) void'(src.pop_front());
  endtask

  task automatic ticks(int n, bit act);
    repeat (n) begin
      cyc(1'b1, act);
      repeat (TICK_DIV - 1) cyc(1'b0, act);
    end
  endtask

  task automatic frame(int act_n, int tot_n);
    ticks(act_n, 1'b1);
    ticks(tot_n - act_n, 1'b0);
  endtask

  task automatic do_reset(logic [2:0] code, logic [6:0] len, bit dual, bit dly, bit pol);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wlen = code; cfg_len = len; cfg_dual = dual;
    cfg_delay = dly; cfg_fs_pol = pol;
    bit_tick = 1'b0; fsync = ~pol; s_valid = 1'b0; s_data = 32'h0;
    repeat (3) @(negedge clk);
    q.delete(); src.delete();
    wleft = 0; pend = 0; prev = 0; exp_line = 0; exp_uf = 0; exp_err = 0; exp_ready = 0;
    feed = 1'b1;
    // R1 reset state
    chk(sdata === 1'b0, "R1", "sdata", int'(sdata), 0);
    chk(s_ready === 1'b0, "R1", "s_ready", int'(s_ready), 0);
    chk(word_strobe === 1'b0, "R1", "word_strobe", int'(word_strobe), 0);
    chk(underflow === 1'b0, "R1", "underflow", int'(underflow), 0);
    chk(fs_error === 1'b0, "R1", "fs_error", int'(fs_error), 0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    // R3 R4 R6: three 16-bit words, no delay, active-low sync, edges exactly one frame apart
    do_reset(3'd2, 7'd2, 1'b0, 1'b0, 1'b0);
    req = "R3";
    push(6);
    frame(1, 48);
    req = "R4";
    frame(1, 48);
    req = "R11";
    ticks(10, 1'b0);

    // R2 R6 R7: 32-bit word, one-bit delay, active-high sync held for 16 ticks
    do_reset(3'd5, 7'd0, 1'b0, 1'b1, 1'b1);
    req = "R2";
    push(2);
    frame(16, 33);
    req = "R7";
    frame(16, 33);
    ticks(4, 1'b0);

    // R5: two phases of one 16-bit word each, delayed, active low
    do_reset(3'd2, 7'd0, 1'b1, 1'b1, 1'b0);
    req = "R5";
    push(4);
    frame(16, 33);
    frame(16, 33);
    ticks(4, 1'b0);

    // R9: fewer samples than words
    do_reset(3'd2, 7'd1, 1'b0, 1'b0, 1'b0);
    req = "R9";
    push(1);
    frame(1, 32);
    feed = 1'b0;
    frame(1, 32);
    ticks(3, 1'b0);

    // R10: sync edge cuts a frame short in mid-word
    do_reset(3'd2, 7'd1, 1'b0, 1'b0, 1'b0);
    req = "R10";
    push(4);
    frame(1, 10);
    frame(1, 32);
    ticks(4, 1'b0);

    // R2 R5 R6: unsupported code falls back to 16 bits, four words per phase, two phases
    do_reset(3'd0, 7'd3, 1'b1, 1'b1, 1'b1);
    req = "R2";
    push(8);
    frame(1, 129);
    req = "R11";
    ticks(6, 1'b0);

    summary();
    $finish;
  end
endmodule